// File: doc/BRIEF.md
# Event Interconnect Channel Controller

This block is the control point for a set of event interconnect channels. Each channel carries one-cycle event pulses from a publishing peripheral to its subscribers. The pulses pass through only while that channel is enabled. Software drives the block through a small register bus. The bus lets it enable and disable channels by mask and define channel groups, each a membership mask over the channels.

Each group has two tasks. The enable task switches all of the group's member channels on, and the disable task switches them off. A task can be started by a register write. It can also subscribe to one of the interconnect channels, and then it fires by itself whenever an event passes through the selected channel. While either task of a group is subscribed, the group's membership mask is frozen.

The channel count and the group count are parameters. The register map is `NUM_CH` ≤ 32 bits wide.

Top module: `evt_xconnect_ctrl`

## Requirements
- R1: After reset, every channel enable, every group mask and every subscription register reads zero.
- R2: Address 0x60 reads the channel enable vector; bit i is 1 when channel i is enabled.
- R3: A write to 0x64 enables each channel whose data bit is 1, and a write to 0x68 disables each channel whose data bit is 1; channels with a 0 bit keep their state, and writing all ones to 0x68 disables every channel.
- R4: Group g owns a membership mask at 0x40 + 4·g, with bit i including channel i; bits at or above `NUM_CH` are dropped and read back as 0.
- R5: Group g has an enable task at 8·g and a disable task at 8·g + 4. Writing a word with bit 0 set triggers the task; writing bit 0 as 0 has no effect. The enable task enables every member channel, and the disable task disables every member channel.
- R6: Each task has a subscription register at its task address + 0x80. Bits [CHW-1:0] select a channel and bit 31 enables the subscription. The register reads back as written, and writing 0 removes the subscription.
- R7: A subscribed task fires when an event pulse arrives on its selected channel while that channel is enabled, and its effect appears on the enable vector after the next clock edge. A pulse on a disabled channel fires nothing.
- R8: When disabling and enabling of one channel coincide in a cycle, from any source (bus clear, bus set, group tasks), the channel ends disabled.
- R9: While the enable or disable task of a group is subscribed, writes to that group's mask are ignored; other groups stay writable.
- R10: `evt_out[i]` equals `evt_in[i]` in the same cycle when channel i is enabled, and is 0 otherwise.
- R11: Without a bus write or an event pulse, the channel enable vector does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_CH | Event pulses from publishers, one per channel |
| evt_out | output | NUM_CH | Event pulses gated by channel enable |

## Verification
The bench sweeps every pair of starting enable state and set/clear mask, so any design that touched zero bits or merged set and clear wrongly shows up at once. A full sweep of group masks against both tasks catches a design that sets or clears the wrong channels. A single event that triggers both tasks of one group exposes a design that lets enable win. A pulse on a disabled channel with a live subscription catches a design that fires tasks from blocked events. Mask writes made while a subscription is active catch a design that lacks the lock, or that locks the wrong group.

// File: rtl/evt_xconnect_ctrl.sv
module evt_xconnect_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int NUM_GRP = 4,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] evt_in,
  output logic [NUM_CH-1:0] evt_out
);
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NTASK = 2 * NUM_GRP;
  localparam logic [AW-1:0] A_STATE = AW'(32'h60);
  localparam logic [AW-1:0] A_SET   = AW'(32'h64);
  localparam logic [AW-1:0] A_CLR   = AW'(32'h68);

  logic [NUM_CH-1:0]               chen_q;
  logic [NUM_GRP-1:0][NUM_CH-1:0]  grp_mask_q;
  logic [NTASK-1:0]                sub_en_q;
  logic [NTASK-1:0][CHW-1:0]       sub_ch_q;
  logic [NTASK-1:0]                task_fire;
  logic [NUM_CH-1:0]               set_vec, clr_vec;

  wire [NUM_CH-1:0] wd_ch = bus_wdata[NUM_CH-1:0];

  assign evt_out = evt_in & chen_q;

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    wire hit_ev = sub_en_q[t] && (32'(sub_ch_q[t]) < NUM_CH) && evt_out[sub_ch_q[t]];
    wire hit_wr = bus_we && bus_addr == AW'(4 * t) && bus_wdata[0];
    assign task_fire[t] = hit_ev | hit_wr;
  end

  always_comb begin
    set_vec = (bus_we && bus_addr == A_SET) ? wd_ch : '0;
    clr_vec = (bus_we && bus_addr == A_CLR) ? wd_ch : '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (task_fire[2*g])   set_vec = set_vec | grp_mask_q[g];
      if (task_fire[2*g+1]) clr_vec = clr_vec | grp_mask_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chen_q <= '0;
    else        chen_q <= (chen_q | set_vec) & ~clr_vec;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    wire locked = sub_en_q[2*g] | sub_en_q[2*g+1];
    always_ff @(posedge clk) begin
      if (!rst_n)
        grp_mask_q[g] <= '0;
      else if (bus_we && bus_addr == AW'(32'h40 + 4 * g) && !locked)
        grp_mask_q[g] <= wd_ch;
    end
  end

  for (genvar t = 0; t < NTASK; t++) begin : g_sub
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sub_en_q[t] <= 1'b0;
        sub_ch_q[t] <= '0;
      end else if (bus_we && bus_addr == AW'(32'h80 + 4 * t)) begin
        sub_en_q[t] <= bus_wdata[DW-1];
        sub_ch_q[t] <= bus_wdata[CHW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATE) bus_rdata[NUM_CH-1:0] = chen_q;
    for (int g = 0; g < NUM_GRP; g++)
      if (bus_addr == AW'(32'h40 + 4 * g)) bus_rdata[NUM_CH-1:0] = grp_mask_q[g];
    for (int t = 0; t < NTASK; t++)
      if (bus_addr == AW'(32'h80 + 4 * t)) begin
        bus_rdata[DW-1]    = sub_en_q[t];
        bus_rdata[CHW-1:0] = sub_ch_q[t];
      end
  end
endmodule

// File: rtl/evt_xconnect_ctrl_chk.sv
module evt_xconnect_ctrl_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_GRP = 4,
  parameter int AW      = 8,
  parameter int DW      = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_we,
  input logic [AW-1:0]                 bus_addr,
  input logic [DW-1:0]                 bus_wdata,
  input logic [NUM_CH-1:0]             evt_in,
  input logic [NUM_CH-1:0]             chen,
  input logic [NUM_GRP-1:0][NUM_CH-1:0] mask,
  input logic [2*NUM_GRP-1:0]          sub_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (chen == '0 && sub_en == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && evt_in == '0) |=> $stable(chen));

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(32'h68) && bus_wdata[NUM_CH-1:0] == '1) |=> chen == '0);

  // R3
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(32'h64) && evt_in == '0)
      |=> (chen & NUM_CH'($past(bus_wdata))) == NUM_CH'($past(bus_wdata)));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lock
    // R9
    mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_en[2*g] || sub_en[2*g+1]) |=> $stable(mask[g]));
  end
endmodule

bind evt_xconnect_ctrl evt_xconnect_ctrl_chk #(
  .NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .AW(AW), .DW(DW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_in(evt_in), .chen(chen_q),
  .mask(grp_mask_q), .sub_en(sub_en_q)
);

// File: tb/evt_xconnect_ctrl_tb.sv
module evt_xconnect_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int NG  = 2;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] evt_in = '0, evt_out;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  evt_xconnect_ctrl #(.NUM_CH(NCH), .NUM_GRP(NG), .AW(8), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .evt_out(evt_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(logic [NCH-1:0] e, output logic [NCH-1:0] o);
    @(negedge clk);
    evt_in = e;
    #1 o = evt_out;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [NCH-1:0] o;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd_chk("R1 state", 8'h60, 0);
    rd_chk("R1 mask0", 8'h40, 0);
    rd_chk("R1 mask1", 8'h44, 0);
    for (int t = 0; t < 2*NG; t++) rd_chk("R1 sub", 8'(8'h80 + 4*t), 0);

    // R2 R3 set/clear sweep
    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 16; m++) begin
        wr(8'h68, 32'hFFFF_FFFF);
        wr(8'h64, a);
        wr(8'h64, m);
        rd_chk("R2 R3 set", 8'h60, a | m);
        wr(8'h68, m);
        rd_chk("R3 clear", 8'h60, (a | m) & ~m);
      end
    wr(8'h64, 32'hF);
    wr(8'h68, 32'hFFFF_FFFF);
    rd_chk("R3 clear all", 8'h60, 0);

    // R4 mask storage, upper bits dropped
    for (int g = 0; g < NG; g++)
      for (int m = 0; m < 16; m++) begin
        wr(8'(8'h40 + 4*g), 32'hF0 | m);
        rd_chk("R4 mask", 8'(8'h40 + 4*g), m);
      end

    // R5 group tasks
    for (int g = 0; g < NG; g++)
      for (int m = 0; m < 16; m++) begin
        wr(8'h68, 32'hF);
        wr(8'(8'h40 + 4*g), m);
        wr(8'h64, 32'hA);
        wr(8'(8*g), 32'h2);
        rd_chk("R5 no trigger", 8'h60, 32'hA);
        wr(8'(8*g), 32'h1);
        rd_chk("R5 enable task", 8'h60, 32'hA | m);
        wr(8'(8*g + 4), 32'h1);
        rd_chk("R5 disable task", 8'h60, (32'hA | m) & ~m);
        wr(8'(8'h40 + 4*g), 0);
      end

    // R10 R11 gating sweep
    for (int s = 0; s < 16; s++)
      for (int e = 0; e < 16; e++) begin
        wr(8'h68, 32'hF);
        wr(8'h64, s);
        pulse(NCH'(e), o);
        chk("R10 gated out", 32'(o), e & s);
        rd_chk("R11 hold", 8'h60, s);
      end

    // R6 subscription register
    wr(8'h84, 32'h8000_0002);
    rd_chk("R6 readback", 8'h84, 32'h8000_0002);
    wr(8'h84, 0);
    rd_chk("R6 removed", 8'h84, 0);

    // R7 subscribed enable task of group 1 on channel 1
    wr(8'h44, 32'h6);
    wr(8'h88, 32'h8000_0001);
    wr(8'h68, 32'hF);
    wr(8'h64, 32'h1);
    pulse(4'b0010, o);
    chk("R7 blocked out", 32'(o), 0);
    rd_chk("R7 disabled channel no fire", 8'h60, 32'h1);
    wr(8'h64, 32'h2);
    pulse(4'b0010, o);
    chk("R7 passed out", 32'(o), 32'h2);
    rd_chk("R7 fired", 8'h60, 32'h7);

    // R9 mask lock
    wr(8'h44, 32'h9);
    rd_chk("R9 locked", 8'h44, 32'h6);
    wr(8'h40, 32'h3);
    rd_chk("R9 other group open", 8'h40, 32'h3);
    wr(8'h88, 0);
    wr(8'h44, 32'h9);
    rd_chk("R9 unlocked", 8'h44, 32'h9);

    // R8 both tasks of group 0 on channel 0
    wr(8'h40, 32'h6);
    wr(8'h80, 32'h8000_0000);
    wr(8'h84, 32'h8000_0000);
    wr(8'h68, 32'hF);
    wr(8'h64, 32'h1);
    pulse(4'b0001, o);
    rd_chk("R8 disable wins", 8'h60, 32'h1);
    wr(8'h84, 0);
    pulse(4'b0001, o);
    rd_chk("R8 enable alone", 8'h60, 32'h7);

    summary();
    $finish;
  end
endmodule